// File: doc/BRIEF.md
# Eight-Channel Two-Level Transfer Arbiter

This block decides which of eight transfer channels owns the single bus master port. Each channel presents a pending-request line, an enable bit, a 2-bit software priority level and a memory-to-memory mode flag. The enable bit gates the request. Among the gated requests, the highest software level wins. If several channels share that level, the channel with the lowest index wins.

A grant is not pre-empted. Once issued, it stays on the same channel until the transfer engine reports the end of the granted transfer with a done pulse while it is not busy. On that event the block picks a new winner, which may be the same channel again. A channel in memory-to-memory mode is the exception: on its done event it steps aside whenever any other enabled channel is requesting, even one of lower level. When nothing is requesting, the grant is dropped.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grantValid` is 0, `grantVec` is 0 and `grantIdx` is 0. An asserted reset clears a grant that is held.
- R2: A channel competes only if its `chReq` bit and its `chEn` bit are both 1. With no such channel, no grant is issued and `grantValid` stays 0.
- R3: Channel i's level is `chLevel[2*i+1:2*i]`, coded 2'b11 very high, 2'b10 high, 2'b01 medium and 2'b00 low. The competing channel with the numerically largest level wins.
- R4: Among competing channels of equal level, the lowest index wins.
- R5: When idle, requests are sampled at a clock edge and the grant appears after that same edge. Before that edge the outputs do not change.
- R6: While a grant is held and no qualified done occurs, the grant does not change. This holds even if higher-level requests arrive.
- R7: A done is qualified only when `xferDone` is 1 and `xferBusy` is 0. A done that arrives with `xferBusy` at 1 is ignored.
- R8: On a qualified done from a channel whose mode flag is 0, a fresh arbitration runs over all competing channels, including the current owner. The result is visible after that edge.
- R9: On a qualified done from a channel whose `chM2m` bit is 1, the owner is left out of the new arbitration if any other channel competes, even one of lower level. If no other channel competes, the owner is granted again.
- R10: On a qualified done with no competing channel, `grantValid`, `grantVec` and `grantIdx` all become 0 after that edge.
- R11: `grantVec` is one-hot when `grantValid` is 1 and zero otherwise. `grantIdx` is the binary index of its set bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chReq | input | 8 | Pending request, one bit per channel |
| chEn | input | 8 | Channel enable, one bit per channel |
| chLevel | input | 16 | Software level, 2 bits per channel, channel i at bits 2i+1:2i |
| chM2m | input | 8 | Memory-to-memory mode flag per channel |
| xferBusy | input | 1 | Transfer engine busy |
| xferDone | input | 1 | End of the granted transfer (qualified when not busy) |
| grantVec | output | 8 | One-hot grant |
| grantIdx | output | 3 | Binary index of the granted channel |
| grantValid | output | 1 | A grant is held |

## Verification
Every grant result is registered once. A decision taken from the inputs present before an edge is visible just after that edge, whether it is a first grant from idle, a re-arbitration on a qualified done, or a release. The bench drives each stimulus a nanosecond after a rising edge and samples one nanosecond after the next rising edge, so each check lands in exactly the cycle where the result is due. The latency check for R5 also samples before that edge, to show that nothing changes early.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic load;     // capture the current winner into the grant register
    logic clear;    // drop the grant
    logic holding;  // a grant is currently owned
  } arbStrobe_t;
endpackage

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int LVL_W  = 2,
  localparam int IDX_W   = $clog2(NUM_CH),
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  arbStrobe_t              strobe,
  input  logic [NUM_CH-1:0]       chReq,
  input  logic [NUM_CH-1:0]       chEn,
  input  logic [NUM_CH*LVL_W-1:0] chLevel,
  input  logic [NUM_CH-1:0]       chM2m,
  output logic [NUM_CH-1:0]       grantVec,
  output logic [IDX_W-1:0]        grantIdx,
  output logic                    candAny
);

  logic [NUM_CH-1:0] eligible;
  logic [NUM_CH-1:0] others;
  logic [NUM_CH-1:0] cand;
  logic              ownerM2m;

  assign eligible = chReq & chEn;
  assign others   = eligible & ~grantVec;
  assign ownerM2m = |(grantVec & chM2m);

  // A memory-to-memory owner yields to any other competitor
  always_comb begin
    if (strobe.holding && ownerM2m && (|others)) cand = others;
    else                                         cand = eligible;
  end

  assign candAny = |cand;

  // Stage one: split candidates by software level
  logic [NUM_CH-1:0] lvlMask [NUM_LVL];

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
        lvlMask[l][i] = cand[i] && (chLevel[i*LVL_W +: LVL_W] == LVL_W'(l));
      end
    end
  end

  // Pick the highest non-empty level
  logic [NUM_CH-1:0] topMask;
  always_comb begin
    logic found;
    found   = 1'b0;
    topMask = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (!found && (|lvlMask[l])) begin
        topMask = lvlMask[l];
        found   = 1'b1;
      end
    end
  end

  // Stage two: lowest index within that level
  logic [NUM_CH-1:0] winVec;
  logic [IDX_W-1:0]  winIdx;
  always_comb begin
    logic taken;
    taken  = 1'b0;
    winVec = '0;
    winIdx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!taken && topMask[i]) begin
        winVec[i] = 1'b1;
        winIdx    = IDX_W'(i);
        taken     = 1'b1;
      end
    end
  end

  // Grant register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grantVec <= '0;
      grantIdx <= '0;
    end else if (strobe.load) begin
      grantVec <= winVec;
      grantIdx <= winIdx;
    end else if (strobe.clear) begin
      grantVec <= '0;
      grantIdx <= '0;
    end
  end

  // R11
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantVec));

  // R11
  grant_idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grantVec != '0) |-> grantVec[grantIdx]);

  // R2
  grant_to_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |=> ((grantVec & ~$past(eligible)) == '0));

  // R9
  m2m_yield_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && strobe.holding && ownerM2m && (|others))
      |=> ((grantVec & $past(grantVec)) == '0));

endmodule

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       candAny,
  input  logic       xferBusy,
  input  logic       xferDone,
  output arbStrobe_t strobe,
  output logic       grantValid
);

  typedef enum logic {ARB_IDLE, ARB_HOLD} arbState_t;

  arbState_t state;
  logic      advance;

  assign advance = (state == ARB_HOLD) && xferDone && !xferBusy;

  always_comb begin
    strobe.holding = (state == ARB_HOLD);
    strobe.load    = ((state == ARB_IDLE) || advance) && candAny;
    strobe.clear   = advance && !candAny;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            state <= ARB_IDLE;
    else if (strobe.load)  state <= ARB_HOLD;
    else if (strobe.clear) state <= ARB_IDLE;
  end

  assign grantValid = (state == ARB_HOLD);

  // R5
  idle_grant_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grantValid && candAny) |=> grantValid);

  // R7
  busy_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && xferBusy) |=> grantValid);

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int LVL_W  = 2,
  localparam int IDX_W = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       chReq,
  input  logic [NUM_CH-1:0]       chEn,
  input  logic [NUM_CH*LVL_W-1:0] chLevel,
  input  logic [NUM_CH-1:0]       chM2m,
  input  logic                    xferBusy,
  input  logic                    xferDone,
  output logic [NUM_CH-1:0]       grantVec,
  output logic [IDX_W-1:0]        grantIdx,
  output logic                    grantValid
);

  arbStrobe_t strobe;
  logic       candAny;

  dma_arb_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .candAny    (candAny),
    .xferBusy   (xferBusy),
    .xferDone   (xferDone),
    .strobe     (strobe),
    .grantValid (grantValid)
  );

  dma_arb_datapath #(
    .NUM_CH (NUM_CH),
    .LVL_W  (LVL_W)
  ) i_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .chReq    (chReq),
    .chEn     (chEn),
    .chLevel  (chLevel),
    .chM2m    (chM2m),
    .grantVec (grantVec),
    .grantIdx (grantIdx),
    .candAny  (candAny)
  );

  // R11
  valid_vec_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid == (grantVec != '0));

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && !(xferDone && !xferBusy)) |=> ($stable(grantVec) && grantValid));

  // R2
  no_request_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!grantValid && ((chReq & chEn) == '0)) |=> !grantValid);

endmodule

// File: tb/test_dma_chan_arbiter.sv
`timescale 1ns/1ps
module test_dma_chan_arbiter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  chReq = '0;
  logic [7:0]  chEn = '0;
  logic [15:0] chLevel = '0;
  logic [7:0]  chM2m = '0;
  logic        xferBusy = 1'b0;
  logic        xferDone = 1'b0;
  logic [7:0]  grantVec;
  logic [2:0]  grantIdx;
  logic        grantValid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_chan_arbiter i_dma_chan_arbiter (
    .clk(clk), .rst_n(rst_n), .chReq(chReq), .chEn(chEn), .chLevel(chLevel),
    .chM2m(chM2m), .xferBusy(xferBusy), .xferDone(xferDone),
    .grantVec(grantVec), .grantIdx(grantIdx), .grantValid(grantValid)
  );

  // Levels A: ch0 low, ch1 medium, ch2 high, ch3 very high,
  //           ch4 very high, ch5 high, ch6 medium, ch7 low
  localparam logic [15:0] LVL_A = 16'h1BE4;
  localparam logic [15:0] LVL_B = 16'h0000;

  // {reqId[3:0], req, en, lvl, m2m, busy, done, expValid, expIdx[2:0]}
  localparam int NV = 16;
  localparam logic [49:0] VEC [NV] = '{
    {4'd2,  8'h00, 8'hFF, LVL_A, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0}, // R2 nothing
    {4'd2,  8'hFF, 8'h00, LVL_A, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0}, // R2 all disabled
    {4'd3,  8'h30, 8'hFF, LVL_A, 8'h00, 1'b0, 1'b0, 1'b1, 3'd4}, // R3 ch4 beats ch5
    {4'd6,  8'hFF, 8'hFF, LVL_A, 8'h00, 1'b0, 1'b0, 1'b1, 3'd4}, // R6 hold
    {4'd7,  8'hFF, 8'hFF, LVL_A, 8'h00, 1'b1, 1'b1, 1'b1, 3'd4}, // R7 busy done
    {4'd8,  8'h0A, 8'hFF, LVL_A, 8'h00, 1'b0, 1'b1, 1'b1, 3'd3}, // R8 rearb
    {4'd8,  8'h08, 8'hFF, LVL_A, 8'h00, 1'b0, 1'b1, 1'b1, 3'd3}, // R8 owner again
    {4'd10, 8'h00, 8'hFF, LVL_A, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0}, // R10 release
    {4'd4,  8'h14, 8'hFF, LVL_B, 8'h00, 1'b0, 1'b0, 1'b1, 3'd2}, // R4 tie
    {4'd8,  8'h14, 8'hFF, LVL_B, 8'h00, 1'b0, 1'b1, 1'b1, 3'd2}, // R8 normal stays
    {4'd9,  8'h14, 8'hFF, LVL_B, 8'h04, 1'b0, 1'b1, 1'b1, 3'd4}, // R9 m2m yields
    {4'd8,  8'h08, 8'hFF, LVL_A, 8'h08, 1'b0, 1'b1, 1'b1, 3'd3}, // R8
    {4'd9,  8'h09, 8'hFF, LVL_A, 8'h08, 1'b0, 1'b1, 1'b1, 3'd0}, // R9 to lower level
    {4'd8,  8'h08, 8'hFF, LVL_A, 8'h08, 1'b0, 1'b1, 1'b1, 3'd3}, // R8
    {4'd9,  8'h08, 8'hFF, LVL_A, 8'h08, 1'b0, 1'b1, 1'b1, 3'd3}, // R9 alone, regranted
    {4'd10, 8'h00, 8'hFF, LVL_A, 8'h08, 1'b0, 1'b1, 1'b0, 3'd0}  // R10 release
  };

  function automatic string reqName(int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chkGrant(string tag, logic v, logic [2:0] idx);
    chk({tag, " valid"}, int'(grantValid), int'(v));
    chk({tag, " idx"}, int'(grantIdx), int'(idx));
    chk({tag, " R11 vec"}, int'(grantVec), v ? (1 << idx) : 0);
  endtask

  task automatic stepEdge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chkGrant("R1 in reset", 1'b0, 3'd0);
    rst_n = 1'b1;
    stepEdge();
    chkGrant("R1 after reset", 1'b0, 3'd0);

    // Table walk
    for (int k = 0; k < NV; k++) begin
      logic [49:0] row;
      row      = VEC[k];
      chReq    = row[45:38];
      chEn     = row[37:30];
      chLevel  = row[29:14];
      chM2m    = row[13:6];
      xferBusy = row[5];
      xferDone = row[4];
      stepEdge();
      chkGrant($sformatf("%s row %0d", reqName(int'(row[49:46])), k), row[3], row[2:0]);
    end

    // R5: grant not visible before the sampling edge, visible after it
    chReq = 8'h40; chEn = 8'hFF; chLevel = LVL_A; chM2m = '0;
    xferBusy = 1'b0; xferDone = 1'b0;
    #1;
    chkGrant("R5 before edge", 1'b0, 3'd0);
    stepEdge();
    chkGrant("R5 after edge", 1'b1, 3'd6);

    // R6: request withdrawn by the owner does not move the grant
    chReq = 8'h01;
    stepEdge();
    chkGrant("R6 owner dropped", 1'b1, 3'd6);

    // R1: reset clears a held grant
    rst_n = 1'b0;
    #1;
    chkGrant("R1 async clear", 1'b0, 3'd0);
    stepEdge();
    chkGrant("R1 held in reset", 1'b0, 3'd0);
    chReq = '0;
    rst_n = 1'b1;
    stepEdge();
    chkGrant("R1 released", 1'b0, 3'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule